// File: doc/BRIEF.md
# Lockable SPI Control-Register Slave

This block is a 16-bit-frame SPI slave that holds a small bank of 11-bit control registers for a gate-driver style device. A host pulls the active-low select low and clocks in exactly one word, MSB first. Bit 15 picks read (1) or write (0), bits 14:11 name the register, and bits 10:0 carry write data. During the same frame the slave shifts back a response: five zero bits, then the 11-bit contents the addressed register held when the frame began.

Register 3 is the control register. Its bits 10:8 are a 3-bit lock code, bits 7:4 a source-current code and bits 3:0 a sink-current code. While the lock code equals 011b the whole bank is writable. Any other code, such as 110b, locks the bank. In that state only the lock code itself can be rewritten, so a host can unlock the bank again. Select, serial clock and data-in cross into the system clock domain through two-flop synchronizers, and serial clock edges are detected there.

Top module: `spi_lockreg_slave`

## Requirements
- R1: A frame is 16 bits, MSB first, while select is low: bit 15 = 1 reads and bit 15 = 0 writes, bits 14:11 hold the address, bits 10:0 hold write data (0x9800 reads register 3, 0x1BFE writes 0x3FE to register 3).
- R2: The serial clock idles low. Data-in is captured on each falling serial-clock edge and data-out changes on rising edges. Data-out is held low while select is high.
- R3: The 16-bit response has bits 15:11 zero and bits 10:0 equal to the addressed register's value at the start of the frame, so a write frame returns the previous contents.
- R4: After reset, register 3 reads 0x3FF (lock code 011b, source code 1111b, sink code 1111b) and every other register reads 0.
- R5: A write takes effect when select rises, and only if exactly 16 falling serial-clock edges occurred. Shorter or longer frames change no register.
- R6: While the lock code (register 3 bits 10:8) is 011b, a write replaces all 11 bits of any implemented register.
- R7: While the lock code is not 011b, writes to registers other than 3 are ignored, and a write to register 3 changes only bits 10:8.
- R8: Reads return register contents whether the bank is locked or not.
- R9: Addresses 7 to 15 are unimplemented: they read as zero and writes to them change nothing.
- R10: Read frames leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ncs_i | input | 1 | Active-low frame select |
| sclk_i | input | 1 | Serial clock, idle low |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial response to host |
| regs_o | output | N_REGS*DW | Register values, register i at bits [i*DW +: DW] |

## Verification
The bench goes after the lock handover. A write of 110b while unlocked must store the full word. A later write while locked must change only the lock bits, so a design that locked itself too early, or kept accepting the low bits, leaves a different register 3 value. Frames of 15 and 17 clocks target a design that commits on a count of at least 16 or on any select rise, which would corrupt register 2. Write frames check that the response shows the old value, which catches a design that commits mid-frame or loads the response late. Reads of unimplemented addresses catch a register mux that wraps the address.

// File: rtl/spi_lockreg_slave.sv
module spi_lockreg_slave #(
  parameter int N_REGS = 7,
  parameter int DW = 11,
  parameter int AW = 4,
  parameter int CTRL_ADDR = 3,
  parameter logic [2:0] UNLOCK_CODE = 3'b011,
  parameter logic [DW-1:0] CTRL_RST = 11'h3FF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ncs_i,
  input  logic                 sclk_i,
  input  logic                 mosi_i,
  output logic                 miso_o,
  output logic [N_REGS*DW-1:0] regs_o
);
  localparam int FW = 1 + AW + DW;
  localparam int CW = $clog2(FW + 2);

  logic [2:0] ncs_sy, sclk_sy;
  logic [1:0] mosi_sy;
  logic [FW-1:0] rx;
  logic [CW-1:0] cnt;
  logic [DW-1:0] tx, rd_val;
  logic [DW-1:0] regs [N_REGS];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ncs_sy  <= '1;
      sclk_sy <= '0;
      mosi_sy <= '0;
    end else begin
      ncs_sy  <= {ncs_sy[1:0], ncs_i};
      sclk_sy <= {sclk_sy[1:0], sclk_i};
      mosi_sy <= {mosi_sy[0], mosi_i};
    end

  wire ncs_q     = ncs_sy[1];
  wire ncs_rise  = ncs_sy[1] & ~ncs_sy[2];
  wire sclk_rise = sclk_sy[1] & ~sclk_sy[2];
  wire sclk_fall = ~sclk_sy[1] & sclk_sy[2];
  wire mosi_q    = mosi_sy[1];
  wire cmd_rd    = rx[FW-1];

  wire [AW-1:0] addr_nx = {rx[AW-2:0], mosi_q};

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < N_REGS; i++)
      if (addr_nx == AW'(i)) rd_val = regs[i];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx     <= '0;
      cnt    <= '0;
      tx     <= '0;
      miso_o <= 1'b0;
    end else if (ncs_q) begin
      cnt    <= '0;
      miso_o <= 1'b0;
    end else begin
      if (sclk_fall) begin
        rx <= {rx[FW-2:0], mosi_q};
        if (cnt != CW'(FW + 1)) cnt <= cnt + 1'b1;
        if (cnt == CW'(AW)) tx <= rd_val;
      end
      if (sclk_rise) begin
        if (cnt > CW'(AW)) begin
          miso_o <= tx[DW-1];
          tx     <= {tx[DW-2:0], 1'b0};
        end else begin
          miso_o <= 1'b0;
        end
      end
    end

  wire          wr_ok    = ncs_rise && (cnt == CW'(FW)) && !cmd_rd;
  wire [AW-1:0] wr_addr  = rx[FW-2:DW];
  wire [DW-1:0] wr_data  = rx[DW-1:0];
  wire          unlocked = regs[CTRL_ADDR][DW-1:DW-3] == UNLOCK_CODE;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < N_REGS; i++)
        regs[i] <= (i == CTRL_ADDR) ? CTRL_RST : '0;
    end else if (wr_ok) begin
      for (int i = 0; i < N_REGS; i++)
        if (wr_addr == AW'(i)) begin
          if (unlocked) regs[i] <= wr_data;
          else if (i == CTRL_ADDR) regs[i][DW-1:DW-3] <= wr_data[DW-1:DW-3];
        end
    end

  for (genvar g = 0; g < N_REGS; g++) begin : g_out
    assign regs_o[g*DW +: DW] = regs[g];
  end
endmodule

// File: rtl/spi_lockreg_slave_chk.sv
module spi_lockreg_slave_chk #(
  parameter int N_REGS = 7,
  parameter int DW = 11,
  parameter int AW = 4,
  parameter int CW = 5,
  parameter int CTRL_ADDR = 3,
  parameter logic [2:0] UNLOCK_CODE = 3'b011
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ncs_q,
  input logic                 ncs_rise,
  input logic [CW-1:0]        cnt,
  input logic                 cmd_rd,
  input logic                 miso_o,
  input logic [N_REGS*DW-1:0] regs_o
);
  localparam int FW = 1 + AW + DW;

  a_r2_miso_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ncs_q && $past(ncs_q)) |-> !miso_o);

  a_r3_header_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt <= CW'(AW)) |-> !miso_o);

  a_r5_commit_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_o) |-> $past(ncs_rise && cnt == CW'(FW) && !cmd_rd));

  a_r7_locked_low_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(regs_o[CTRL_ADDR*DW+DW-1 -: 3]) != UNLOCK_CODE)
      |-> $stable(regs_o[CTRL_ADDR*DW +: DW-3]));
endmodule

bind spi_lockreg_slave spi_lockreg_slave_chk #(
  .N_REGS(N_REGS), .DW(DW), .AW(AW), .CW(CW),
  .CTRL_ADDR(CTRL_ADDR), .UNLOCK_CODE(UNLOCK_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ncs_q(ncs_q), .ncs_rise(ncs_rise),
  .cnt(cnt), .cmd_rd(cmd_rd), .miso_o(miso_o), .regs_o(regs_o)
);

// File: tb/spi_lockreg_slave_bench.sv
module spi_lockreg_slave_bench;
  logic clk = 0, rst_n = 0, ncs = 1, sclk = 0, mosi = 0;
  wire miso;
  wire [76:0] regs;
  int n_vec = 0, n_bad = 0;
  logic [10:0] m [7];
  logic [15:0] exp_q[$], got_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  spi_lockreg_slave u_spi_lockreg_slave (.clk(clk), .rst_n(rst_n), .ncs_i(ncs),
    .sclk_i(sclk), .mosi_i(mosi), .miso_o(miso), .regs_o(regs));

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    if (got_q.size() > 0 && exp_q.size() > 0)
      check(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
  end

  task automatic hb();
    repeat (8) @(negedge clk);
  endtask

  function automatic logic [15:0] mk(input logic rd, input logic [3:0] a, input logic [10:0] d);
    return {rd, a, d};
  endfunction

  task automatic frame(input logic [15:0] w, input int nbits, input string tag);
    logic [15:0] resp = '0;
    logic [3:0] a = w[14:11];
    if (nbits == 16) begin
      exp_q.push_back(a < 7 ? {5'b0, m[a]} : 16'h0);
      tag_q.push_back(tag);
    end
    ncs = 0; hb();
    for (int i = 0; i < nbits; i++) begin
      sclk = 1; mosi = (i < 16) ? w[15-i] : 1'b0; hb();
      resp = {resp[14:0], miso};
      sclk = 0; hb();
    end
    ncs = 1;
    if (nbits == 16) got_q.push_back(resp);
    if (nbits == 16 && !w[15] && a < 7) begin
      if (m[3][10:8] == 3'b011) m[a] = w[10:0];
      else if (a == 3) m[3][10:8] = w[10:8];
    end
    repeat (4) hb();
    check({tag, " R2 idle"}, {15'b0, miso}, 16'h0);
  endtask

  task automatic check_regs(input string tag);
    for (int i = 0; i < 7; i++) check(tag, {5'b0, regs[i*11 +: 11]}, {5'b0, m[i]});
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 7; i++) m[i] = (i == 3) ? 11'h3FF : 11'h0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check_regs("R4 reset");
    frame(16'h9800, 16, "R1 R3 read ctrl");
    frame(16'h1BFE, 16, "R3 write returns old");
    check_regs("R6 ctrl write");
    frame(16'h9800, 16, "R1 read back 0x3FE");
    frame(mk(0, 1, 11'h5A5), 16, "R6 write r1");
    frame(mk(1, 1, 0), 16, "R1 read r1");
    frame(mk(0, 6, 11'h2C3), 16, "R6 write r6");
    check_regs("R6 regs");
    frame(mk(0, 9, 11'h7FF), 16, "R9 write unimpl");
    frame(mk(1, 9, 0), 16, "R9 read unimpl zero");
    check_regs("R9 regs unchanged");
    frame(mk(0, 2, 11'h155), 15, "R5 short");
    check_regs("R5 short frame discarded");
    frame(mk(0, 2, 11'h155), 17, "R5 long");
    check_regs("R5 long frame discarded");
    frame(mk(0, 3, {3'b110, 8'h12}), 16, "R6 lock write");
    check_regs("R6 lock word stored");
    frame(mk(0, 1, 11'h0F0), 16, "R7 locked write r1");
    frame(mk(0, 3, {3'b110, 8'h00}), 16, "R7 locked write ctrl");
    check_regs("R7 locked");
    frame(mk(1, 1, 0), 16, "R8 read while locked");
    frame(mk(1, 3, 0), 16, "R8 read ctrl locked");
    frame(mk(0, 3, {3'b011, 8'h55}), 16, "R7 unlock");
    check_regs("R7 only lock bits changed");
    frame(mk(0, 2, 11'h6AB), 16, "R6 write after unlock");
    frame(mk(1, 2, 0), 16, "R10 read r2");
    frame(mk(1, 0, 0), 16, "R10 read r0");
    check_regs("R10 reads change nothing");
    repeat (20) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule